// File: doc/BRIEF.md
# Non-Audio Burst Sync Detector

This block sits after a digital audio interface receiver and inspects the stream of decoded samples to decide whether it carries compressed data bursts instead of linear PCM. It looks for a fixed 96-bit burst preamble, which is six consecutive 16-bit words taken from the top of successive samples. When it sees the whole preamble it raises a detect flag. The flag stays up while new preambles keep arriving within a window of frames, and drops when the window runs out. The reported non-audio indicator is this flag ORed with the audio/non-audio bit from the received channel status.

Samples pass through the block unchanged on a valid/ready stream. Output valid follows input valid, and input ready follows output ready, so back-pressure from downstream reaches the source with no added storage. A word counts toward the preamble only in a cycle where both valid and ready are high. A stalled word is neither lost nor counted twice. The frame strobe, the channel-status bit, the sync pulse and the indicators are plain level and pulse pins.

Top module: `nonaudio_sync_detect`

## Requirements
- R1: The compared key of each sample is bits [23:8]. The preamble is the key sequence 0x0000, 0x0000, 0x0000, 0x0000, 0xF872, 0x4E1F. Bits [7:0] have no effect on matching.
- R2: Keys are matched over consecutive accepted samples in arrival order. A key that breaks the sequence restarts the search. If that key is 0x0000, it counts as the first preamble word. If four zero keys have been matched, further zero keys keep those four zeros matched.
- R3: From the clock edge that accepts the sixth preamble word, `detect` is 1. A partial preamble never sets it.
- R4: While `detect` is 1, each `frame_tick` cycle advances a frame count. Every completed preamble resets the count to zero. On the 4096th frame tick with no new preamble, `detect` returns to 0.
- R5: `nonaudio` equals `detect` OR `cs_nonaudio` at all times. The channel-status bit alone can drive it high.
- R6: `m_data` equals `s_data`, `m_valid` equals `s_valid` and `s_ready` equals `m_ready`. A sample is consumed only when `s_valid` and `s_ready` are both 1.
- R7: `sync_found` is a one-cycle pulse. It is registered on the edge that accepts the sixth preamble word.
- R8: A synchronous `rst` clears the match progress, the frame count, `detect` and `sync_found`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample ready (follows m_ready) |
| s_data | input | 24 | Input sample word |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 24 | Output sample word, unchanged |
| frame_tick | input | 1 | One-cycle strobe per received frame |
| cs_nonaudio | input | 1 | Received channel-status non-audio bit |
| sync_found | output | 1 | Pulse on each complete preamble |
| detect | output | 1 | Preamble-based detect flag |
| nonaudio | output | 1 | Reported non-audio indicator |

## Verification
The bench presents a five-zero run before the tail words. A matcher that resets on every mismatch would miss this preamble, and one that ignores the low byte wrongly would fail on the varied low bits. It stalls the final word with ready low for several cycles. A design that counts unaccepted words would pulse too early. It probes the hold window at exactly 4095 and 4096 frame ticks, both after a first match and after a re-arming match, which exposes an off-by-one window or a count that does not restart. It also shows that the channel-status bit alone raises the indicator, that a partial preamble leaves the flag low, and that reset in the middle of a preamble discards the progress.

// File: rtl/nsd_pkg.sv
package nsd_pkg;
  localparam int SAMPLE_W  = 24;
  localparam int KEY_W     = 16;
  localparam int KEY_LSB   = SAMPLE_W - KEY_W;
  localparam int N_WORDS   = 6;
  localparam int ZERO_RUN  = 4;
  localparam int IDX_W     = $clog2(N_WORDS);

  function automatic logic [KEY_W-1:0] preamble_word(input int k);
    case (k)
      4:       preamble_word = 16'hF872;
      5:       preamble_word = 16'h4E1F;
      default: preamble_word = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/nsd_matcher.sv
module nsd_matcher
  import nsd_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  logic [KEY_W-1:0]    key,
  output logic                hit
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [N_WORDS-1:0] eq;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_cmp
    assign eq[g] = (key == preamble_word(g));
  end

  always_comb begin
    hit   = 1'b0;
    idx_d = idx_q;
    if (accept) begin
      if (eq[idx_q]) begin
        if (idx_q == IDX_W'(N_WORDS-1)) begin
          hit   = 1'b1;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else if (eq[0]) begin
        idx_d = (idx_q == IDX_W'(ZERO_RUN)) ? IDX_W'(ZERO_RUN) : IDX_W'(1);
      end else begin
        idx_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx_d;
  end

  // R2: progress never leaves the preamble range
  p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
    idx_q < IDX_W'(N_WORDS));
  // R6: no accepted sample, no progress change
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(idx_q));
  // R2: a non-zero wrong key always restarts at zero
  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && !eq[idx_q] && !eq[0]) |=> idx_q == '0);
endmodule

// File: rtl/nsd_hold.sv
module nsd_hold #(
  parameter int HOLD_FRAMES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic frame_tick,
  output logic detect
);
  localparam int CNT_W = $clog2(HOLD_FRAMES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_FRAMES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             det_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      det_q <= 1'b0;
      cnt_q <= '0;
    end else if (hit) begin
      det_q <= 1'b1;
      cnt_q <= '0;
    end else if (det_q && frame_tick) begin
      if (cnt_q == LAST) begin
        det_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign detect = det_q;

  // R3: a match sets the flag with a fresh window
  p_set_on_hit_r3: assert property (@(posedge clk) disable iff (rst)
    hit |=> (det_q && cnt_q == '0));
  // R4: window expiry drops the flag
  p_expire_r4: assert property (@(posedge clk) disable iff (rst)
    (det_q && frame_tick && !hit && cnt_q == LAST) |=> !det_q);
  // R4: count idles at zero while the flag is low
  p_idle_count_r4: assert property (@(posedge clk) disable iff (rst)
    !det_q |-> cnt_q == '0);
  // R4: no frame tick and no match keeps the count
  p_count_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (!frame_tick && !hit) |=> $stable(cnt_q));
endmodule

// File: rtl/nonaudio_sync_detect.sv
module nonaudio_sync_detect
  import nsd_pkg::*;
#(
  parameter int HOLD_FRAMES = 4096
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [SAMPLE_W-1:0] m_data,
  input  logic                frame_tick,
  input  logic                cs_nonaudio,
  output logic                sync_found,
  output logic                detect,
  output logic                nonaudio
);
  logic accept;
  logic hit;
  logic found_q;

  assign m_valid = s_valid;
  assign s_ready = m_ready;
  assign m_data  = s_data;
  assign accept  = s_valid && m_ready;

  nsd_matcher u_match (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .key    (s_data[SAMPLE_W-1:KEY_LSB]),
    .hit    (hit)
  );

  nsd_hold #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .hit        (hit),
    .frame_tick (frame_tick),
    .detect     (detect)
  );

  always_ff @(posedge clk) begin
    if (rst) found_q <= 1'b0;
    else     found_q <= hit;
  end

  assign sync_found = found_q;
  assign nonaudio   = detect | cs_nonaudio;

  // R7: the pulse lasts one cycle
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    sync_found |=> !sync_found);
  // R3: the pulse and the flag appear together
  p_found_sets_r3: assert property (@(posedge clk) disable iff (rst)
    sync_found |-> detect);
  // R5: the flag always forces the indicator
  p_flag_drives_r5: assert property (@(posedge clk) disable iff (rst)
    detect |-> nonaudio);
endmodule

// File: tb/test_nonaudio_sync_detect.sv
module test_nonaudio_sync_detect;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;
  // {expected sync_found, sample}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 24'h0000_12}, {1'b0, 24'h0000_FF}, {1'b0, 24'h0000_00},
    {1'b0, 24'h0000_A5}, {1'b0, 24'hF872_3C}, {1'b1, 24'h4E1F_77},
    {1'b0, 24'h0000_01}, {1'b0, 24'h0000_02}, {1'b0, 24'h0000_03},
    {1'b0, 24'hF872_00}, {1'b0, 24'h0000_00}, {1'b0, 24'h0000_10},
    {1'b0, 24'h0000_20}, {1'b0, 24'h0000_30}, {1'b0, 24'h0000_40},
    {1'b0, 24'hF872_55}, {1'b1, 24'h4E1F_AA}, {1'b0, 24'h0000_00},
    {1'b0, 24'h0000_00}, {1'b0, 24'h0000_00}, {1'b0, 24'h0000_00},
    {1'b0, 24'hF872_00}, {1'b0, 24'h4E10_00}
  };

  logic clk = 0, rst = 1;
  logic s_valid = 0, m_ready = 1, frame_tick = 0, cs_nonaudio = 0;
  logic [23:0] s_data = '0;
  logic s_ready, m_valid, sync_found, detect, nonaudio;
  logic [23:0] m_data;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nonaudio_sync_detect i_nonaudio_sync_detect (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .frame_tick(frame_tick),
    .cs_nonaudio(cs_nonaudio), .sync_found(sync_found), .detect(detect), .nonaudio(nonaudio)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one accepted word; samples outputs at the following negedge
  task automatic send(input logic [23:0] w);
    s_valid = 1; s_data = w;
    @(posedge clk); @(negedge clk);
    s_valid = 0;
  endtask

  task automatic full_match();
    send(24'h0); send(24'h0); send(24'h0); send(24'h0); send(24'hF87200);
    send(24'h4E1F00);
  endtask

  task automatic ticks(input int n);
    frame_tick = 1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    frame_tick = 0;
  endtask

  task automatic do_reset();
    rst = 1; repeat (2) @(posedge clk); @(negedge clk); rst = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R8 reset state
    chk("R8 detect after reset", detect, 0);
    chk("R8 sync_found after reset", sync_found, 0);
    chk("R5 nonaudio idle", nonaudio, 0);
    // R5 channel-status bit alone
    cs_nonaudio = 1; #1;
    chk("R5 cs alone drives nonaudio", nonaudio, 1);
    chk("R5 cs does not set detect", detect, 0);
    cs_nonaudio = 0; #1;
    // R6 pass-through
    s_data = 24'hABCDEF; s_valid = 1; m_ready = 0; #1;
    chk("R6 m_data", m_data, 24'hABCDEF);
    chk("R6 m_valid", m_valid, 1);
    chk("R6 s_ready low", s_ready, 0);
    m_ready = 1; s_valid = 0; #1;
    chk("R6 s_ready high", s_ready, 1);
    chk("R6 m_valid low", m_valid, 0);
    @(negedge clk);

    // table walk: R1 R2 R7
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][23:0]);
      chk($sformatf("R2 R1 R7 vector %0d sync_found", i), sync_found, VEC[i][24]);
    end
    chk("R3 detect after table", detect, 1);

    // R3 partial preamble does not assert; R8 reset mid-preamble
    do_reset();
    send(24'h0); send(24'h0); send(24'h0); send(24'h0); send(24'hF87200);
    chk("R3 partial leaves detect low", detect, 0);
    do_reset();
    send(24'h4E1F00);
    chk("R8 reset discards progress", sync_found, 0);
    chk("R8 detect still low", detect, 0);

    // R6 back-pressure stalls the final word
    send(24'h0); send(24'h0); send(24'h0); send(24'h0); send(24'hF87200);
    m_ready = 0; s_valid = 1; s_data = 24'h4E1F00;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R6 stalled word not counted", sync_found, 0);
    chk("R6 stalled detect low", detect, 0);
    m_ready = 1;
    @(posedge clk); @(negedge clk); s_valid = 0;
    chk("R6 R7 word counted once accepted", sync_found, 1);
    @(negedge clk);
    chk("R7 pulse is one cycle", sync_found, 0);

    // R4 hold window
    do_reset();
    full_match();
    chk("R3 detect set", detect, 1);
    ticks(4095);
    chk("R4 detect held at 4095 frames", detect, 1);
    full_match();
    chk("R4 rematch pulse", sync_found, 1);
    ticks(4095);
    chk("R4 window restarted by match", detect, 1);
    ticks(1);
    chk("R4 detect cleared at 4096 frames", detect, 0);
    chk("R5 nonaudio follows cleared flag", nonaudio, 0);
    cs_nonaudio = 1; #1;
    chk("R5 OR with cs bit", nonaudio, 1);
    cs_nonaudio = 0;

    // R8 reset clears a set flag
    full_match();
    do_reset();
    chk("R8 reset clears detect", detect, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule